// File: doc/BRIEF.md
# Segmented Base-and-Bound Address Translator

The translator relocates and guards every memory reference using a small table of segment descriptors, each a base and a bound. An incoming effective address carries a segment selector in its upper bits and an offset in its lower bits. The offset width sets the largest size a segment can have. The descriptor is picked in one of two ways. The selector can come from the address itself. Otherwise the access type picks it: instruction fetches use the code descriptor and data accesses use the data descriptor. The physical address is the offset added to the selected base. The same cycle compares that sum against the bound, so segments of any size reject references past their end.

The descriptor table is normally reloaded when the active process changes. Only a configuration write marked privileged can change it. A write without privilege leaves the table alone and raises a one-cycle error pulse. Each translation result is registered and appears one clock after the request.

Top module: `segxlat`

## Requirements
- R1: After reset, out_valid, out_viol and priv_err are 0. Every descriptor has base 0 and bound 0, so any translated reference flags a violation until the table is loaded.
- R2: For an accepted request, out_pa equals the selected base plus the zero-extended offset (req_ea[OFF_W-1:0]), truncated to PA_W bits.
- R3: out_viol is 1 when the full-precision sum base+offset is greater than or equal to the bound. This includes a sum that carries beyond PA_W bits. The reference is legal only when the sum is strictly below the bound.
- R4: When req_explicit is 0, a request with req_fetch=1 uses descriptor 0 (code) and a request with req_fetch=0 uses descriptor 1 (data), whatever the upper address bits hold.
- R5: When req_explicit is 1, the descriptor index is req_ea[OFF_W+SEG_BITS-1:OFF_W].
- R6: A write with cfg_we=1 and cfg_priv=1 stores cfg_base and cfg_bound into descriptor cfg_idx at the clock edge. A translation requested in the same cycle uses the descriptor's previous contents.
- R7: A write with cfg_we=1 and cfg_priv=0 leaves the table unchanged. It drives priv_err to 1 for exactly the following cycle. priv_err is 0 at all other times.
- R8: out_valid is req_valid delayed by one clock. In a cycle following no request, out_pa and out_viol keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| req_explicit | input | 1 | 1 = selector taken from address bits |
| req_ea | input | SEG_BITS+OFF_W | Effective address: selector above offset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_priv | input | 1 | Writer is in privileged mode |
| cfg_idx | input | SEG_BITS | Descriptor being written |
| cfg_base | input | PA_W | New base value |
| cfg_bound | input | PA_W | New bound value (exclusive limit) |
| out_valid | output | 1 | Translation result present |
| out_pa | output | PA_W | Physical address |
| out_viol | output | 1 | Reference outside its segment |
| priv_err | output | 1 | Pulse: unprivileged write attempt |

## Verification
Every result (out_valid, out_pa, out_viol and priv_err) is due exactly one clock after the cycle in which its stimulus is presented. A table write takes effect at that same edge, so the next cycle's request sees the new descriptor. The bench drives inputs on the falling edge and samples outputs on the following falling edge, half a period after the capturing rising edge. It computes each expected value from a shadow table read before that cycle's write is applied. This makes same-cycle write-and-lookup and privilege-rejected writes check against the correct descriptor contents.

// File: rtl/segxlat.sv
module segxlat #(
  parameter int SEG_BITS = 2,
  parameter int OFF_W    = 12,
  parameter int PA_W     = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic                      req_fetch,
  input  logic                      req_explicit,
  input  logic [SEG_BITS+OFF_W-1:0] req_ea,
  input  logic                      cfg_we,
  input  logic                      cfg_priv,
  input  logic [SEG_BITS-1:0]       cfg_idx,
  input  logic [PA_W-1:0]           cfg_base,
  input  logic [PA_W-1:0]           cfg_bound,
  output logic                      out_valid,
  output logic [PA_W-1:0]           out_pa,
  output logic                      out_viol,
  output logic                      priv_err
);
  localparam int NSEG = 1 << SEG_BITS;
  localparam int EA_W = SEG_BITS + OFF_W;

  logic [PA_W-1:0] base_q  [NSEG];
  logic [PA_W-1:0] bound_q [NSEG];

  logic [SEG_BITS-1:0] sel;
  logic [PA_W:0]       sum;

  assign sel = req_explicit ? req_ea[EA_W-1:OFF_W]
                            : (req_fetch ? SEG_BITS'(0) : SEG_BITS'(1));
  assign sum = {1'b0, base_q[sel]} + (PA_W+1)'(req_ea[OFF_W-1:0]);

  for (genvar g = 0; g < NSEG; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[g]  <= '0;
        bound_q[g] <= '0;
      end else if (cfg_we && cfg_priv && cfg_idx == SEG_BITS'(g)) begin
        base_q[g]  <= cfg_base;
        bound_q[g] <= cfg_bound;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pa    <= '0;
      out_viol  <= 1'b0;
      priv_err  <= 1'b0;
    end else begin
      out_valid <= req_valid;
      priv_err  <= cfg_we && !cfg_priv;
      if (req_valid) begin
        out_pa   <= sum[PA_W-1:0];
        out_viol <= sum >= {1'b0, bound_q[sel]};
      end
    end
  end
endmodule

module segxlat_chk #(
  parameter int SEG_BITS = 2,
  parameter int OFF_W    = 12,
  parameter int PA_W     = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      req_valid,
  input logic [SEG_BITS+OFF_W-1:0] req_ea,
  input logic                      cfg_we,
  input logic                      cfg_priv,
  input logic                      out_valid,
  input logic [PA_W-1:0]           out_pa,
  input logic                      out_viol,
  input logic                      priv_err
);
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) out_valid == $past(req_valid)); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> ($stable(out_pa) && $stable(out_viol))); // R8
  AST_PRIV_PULSE: assert property (@(posedge clk) disable iff (!rst_n) priv_err == $past(cfg_we && !cfg_priv)); // R7
  AST_LEGAL_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_viol) |-> (PA_W+1)'(out_pa) >= (PA_W+1)'($past(req_ea[OFF_W-1:0]))); // R3
  AST_RESET_QUIET: assert property (@(posedge clk) !$past(rst_n) |-> (!out_valid && !out_viol && !priv_err)); // R1
endmodule

bind segxlat segxlat_chk #(.SEG_BITS(SEG_BITS), .OFF_W(OFF_W), .PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ea(req_ea),
  .cfg_we(cfg_we), .cfg_priv(cfg_priv), .out_valid(out_valid),
  .out_pa(out_pa), .out_viol(out_viol), .priv_err(priv_err)
);

// File: tb/segxlat_bench.sv
`timescale 1ns/1ps
module segxlat_bench;
  localparam int SB = 2, OW = 12, PW = 16, EW = SB + OW;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_fetch = 0, req_explicit = 0;
  logic [EW-1:0] req_ea = '0;
  logic cfg_we = 0, cfg_priv = 0;
  logic [SB-1:0] cfg_idx = '0;
  logic [PW-1:0] cfg_base = '0, cfg_bound = '0;
  logic out_valid, out_viol, priv_err;
  logic [PW-1:0] out_pa;

  int checks = 0, failures = 0;
  logic [PW-1:0] mb [4];
  logic [PW-1:0] mbd [4];
  logic [PW-1:0] last_pa = '0;
  logic last_viol = 0;

  always #10 clk = ~clk;

  segxlat #(.SEG_BITS(SB), .OFF_W(OW), .PA_W(PW)) u_segxlat (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_fetch(req_fetch),
    .req_explicit(req_explicit), .req_ea(req_ea), .cfg_we(cfg_we),
    .cfg_priv(cfg_priv), .cfg_idx(cfg_idx), .cfg_base(cfg_base),
    .cfg_bound(cfg_bound), .out_valid(out_valid), .out_pa(out_pa),
    .out_viol(out_viol), .priv_err(priv_err));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [SB-1:0] pick(input bit f, input bit ex, input logic [EW-1:0] ea);
    return ex ? ea[EW-1:OW] : (f ? 2'd0 : 2'd1);
  endfunction

  task automatic step(input string tag, input bit v, input bit f, input bit ex,
                      input logic [EW-1:0] ea, input bit we, input bit pr,
                      input logic [SB-1:0] idx, input logic [PW-1:0] b, input logic [PW-1:0] bd);
    logic [SB-1:0] s;
    logic [PW:0] sum;
    logic ev;
    req_valid = v; req_fetch = f; req_explicit = ex; req_ea = ea;
    cfg_we = we; cfg_priv = pr; cfg_idx = idx; cfg_base = b; cfg_bound = bd;
    s = pick(f, ex, ea);
    sum = {1'b0, mb[s]} + (PW+1)'(ea[OW-1:0]);
    ev = sum >= {1'b0, mbd[s]};
    if (we && pr) begin mb[idx] = b; mbd[idx] = bd; end
    @(negedge clk);
    req_valid = 0; cfg_we = 0;
    chk({tag, " R8 valid"}, 32'(out_valid), 32'(v));
    chk({tag, " R7 priv_err"}, 32'(priv_err), 32'(we && !pr));
    if (v) begin
      chk({tag, " R2 pa"}, 32'(out_pa), 32'(sum[PW-1:0]));
      chk({tag, " R3 viol"}, 32'(out_viol), 32'(ev));
      last_pa = sum[PW-1:0]; last_viol = ev;
    end else begin
      chk({tag, " R8 hold pa"}, 32'(out_pa), 32'(last_pa));
      chk({tag, " R8 hold viol"}, 32'(out_viol), 32'(last_viol));
    end
  endtask

  task automatic wr(input string tag, input bit pr, input logic [SB-1:0] idx,
                    input logic [PW-1:0] b, input logic [PW-1:0] bd);
    step(tag, 0, 0, 0, '0, 1, pr, idx, b, bd);
  endtask

  task automatic rd(input string tag, input bit f, input bit ex, input logic [EW-1:0] ea);
    step(tag, 1, f, ex, ea, 0, 0, '0, '0, '0);
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    for (int i = 0; i < 4; i++) begin mb[i] = '0; mbd[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 reset valid", 32'(out_valid), 0);
    chk("R1 reset viol", 32'(out_viol), 0);
    chk("R1 reset priv_err", 32'(priv_err), 0);
    rd("R1 empty table", 1, 0, 14'h0000);
    chk("R1 empty table violates", 32'(out_viol), 1);

    wr("R6 load code", 1, 0, 16'h1000, 16'h1800);
    wr("R6 load data", 1, 1, 16'h4000, 16'h4100);
    wr("R6 load seg2", 1, 2, 16'h8000, 16'hA000);
    wr("R6 load seg3", 1, 3, 16'hFFF0, 16'hFFFF);

    rd("R4 fetch implied", 1, 0, 14'h3123);
    chk("R4 fetch uses entry0", 32'(out_pa), 32'h1123);
    rd("R4 data implied", 0, 0, 14'h2050);
    chk("R4 data uses entry1", 32'(out_pa), 32'h4050);
    rd("R5 explicit seg2", 0, 1, 14'h2234);
    chk("R5 explicit entry2", 32'(out_pa), 32'h8234);
    rd("R5 explicit seg1 fetch", 1, 1, 14'h1010);

    rd("R3 last legal", 0, 0, 14'h00FF);
    chk("R3 below bound legal", 32'(out_viol), 0);
    rd("R3 at bound", 0, 0, 14'h0100);
    chk("R3 equal bound violates", 32'(out_viol), 1);
    rd("R3 carry out", 0, 1, 14'h3020);
    chk("R3 wrap violates", 32'(out_viol), 1);

    step("R6 same cycle", 1, 1, 0, 14'h0010, 1, 1, 0, 16'h2000, 16'h3000);
    chk("R6 old entry used", 32'(out_pa), 32'h1010);
    rd("R6 new entry used", 1, 0, 14'h0010);
    chk("R6 new entry pa", 32'(out_pa), 32'h2010);

    wr("R7 unpriv write", 0, 0, 16'h0000, 16'hFFFF);
    step("R7 idle after", 0, 0, 0, '0, 0, 0, 0, '0, '0);
    rd("R7 table unchanged", 1, 0, 14'h0020);
    chk("R7 entry0 kept", 32'(out_pa), 32'h2020);

    step("R8 idle hold", 0, 1, 1, 14'h3FFF, 0, 0, 0, '0, '0);

    for (int i = 0; i < 400; i++) begin
      bit v, f, ex, we, pr;
      v = 1'($urandom); f = 1'($urandom); ex = 1'($urandom);
      we = ($urandom % 6) == 0; pr = 1'($urandom);
      step("RND", v, f, ex, 14'($urandom), we, pr, 2'($urandom),
           16'($urandom), 16'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule